// File: doc/BRIEF.md
# Instruction Cycle Accounting Unit

This block sits beside a simple in-order pipeline and prices each instruction as it retires. The pipeline presents, for one cycle per retiring instruction, the instruction class, a base cycle count, up to two source register indices with valid flags, the destination index of a load, a branch-taken flag and a delay-slot flag. The block answers in the same cycle with the instruction's cost. That cost is the base count plus any penalty cycles that the block works out itself.

Two penalties exist. A register written by a load is still in flight for the instruction that immediately follows, so each source operand of that next instruction that names it costs one extra cycle. A taken control transfer that has no delay slot costs one extra cycle to refill. Saturating counters keep the accumulated cycles, the load-stall cycles, the control-transfer stall cycles, and the numbers of taken and untaken branches. A register holds the cost of the most recent instruction.

Top module: `cyc_acct`

## Requirements
- R1: After a synchronous reset every counter and the last-cost register read zero, and no register is marked as an in-flight load, so the first instruction never stalls.
- R2: The class code on `cls_i` is 0 execute, 1 control transfer, 2 load, 3 store, 4 block load, 5 block store; codes 6 and 7 are priced like 4. `cost_o` equals `base_i` plus the load-stall cycles plus the branch penalty. Execute and store compare both sources with the in-flight mask.
- R3: A retiring load marks only its destination register, and that mark is seen only by the next retiring instruction. Every retirement replaces the mask, and cycles without a retirement leave it unchanged.
- R4: Loads and control transfers compare only source A (the address or target register) with the mask. Source B is ignored for them.
- R5: A source whose valid flag is low never adds a stall cycle.
- R6: A taken control transfer with `dslot_i` low adds one cycle and increments the control-transfer stall counter. With `dslot_i` high, or when the branch is not taken, there is no penalty.
- R7: Each control transfer increments the taken counter if `taken_i` is high and the untaken counter otherwise. Other classes leave both counters unchanged.
- R8: Block load and block store cost exactly `base_i`, with no stall check, and they clear the in-flight mask.
- R9: On each retirement the total counter adds the cost, the load-stall counter adds the number of stalled sources (0 to 2), and `last_cost_o` takes the cost one clock later.
- R10: Every counter is `CNT_W` bits wide (default 32) and saturates at all-ones instead of wrapping.
- R11: In a cycle with `ret_i` low, no counter and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ret_i | input | 1 | An instruction retires this cycle |
| cls_i | input | 3 | Instruction class code |
| base_i | input | BASE_W | Base cycle count |
| src_a_i | input | log2(NREG) | Source A register index |
| src_a_vld_i | input | 1 | Source A present |
| src_b_i | input | log2(NREG) | Source B register index |
| src_b_vld_i | input | 1 | Source B present |
| ld_dst_i | input | log2(NREG) | Load destination register |
| taken_i | input | 1 | Control transfer was taken |
| dslot_i | input | 1 | Control transfer has a delay slot |
| cost_o | output | BASE_W+2 | Cost of the retiring instruction |
| last_cost_o | output | BASE_W+2 | Cost of the previous retirement |
| tot_o | output | CNT_W | Total cycles |
| ld_stall_o | output | CNT_W | Load-stall cycles |
| cti_stall_o | output | CNT_W | Control-transfer stall cycles |
| taken_o | output | CNT_W | Taken branches |
| untaken_o | output | CNT_W | Untaken branches |

## Verification
The assertions assume that every input holds steady for the whole cycle in which `ret_i` is high. They also assume that `CNT_W` is at least as wide as a cost, so one addition cannot jump past saturation more than once. The stimulus changes inputs only on the falling edge and keeps base values within `BASE_W`. It sets the counter width to 12 bits so that saturation can be reached within a short run. Directed sequences cover load-to-use pairs, idle gaps, ignored operands and both kinds of branch, and the scoreboard compares every retirement against a separate model.

// File: rtl/cyc_acct.sv
module cyc_acct #(
  parameter int CNT_W  = 32,
  parameter int BASE_W = 8,
  parameter int NREG   = 16,
  localparam int IDX_W  = $clog2(NREG),
  localparam int COST_W = BASE_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ret_i,
  input  logic [2:0]        cls_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [IDX_W-1:0]  src_a_i,
  input  logic              src_a_vld_i,
  input  logic [IDX_W-1:0]  src_b_i,
  input  logic              src_b_vld_i,
  input  logic [IDX_W-1:0]  ld_dst_i,
  input  logic              taken_i,
  input  logic              dslot_i,
  output logic [COST_W-1:0] cost_o,
  output logic [COST_W-1:0] last_cost_o,
  output logic [CNT_W-1:0]  tot_o,
  output logic [CNT_W-1:0]  ld_stall_o,
  output logic [CNT_W-1:0]  cti_stall_o,
  output logic [CNT_W-1:0]  taken_o,
  output logic [CNT_W-1:0]  untaken_o
);

  localparam logic [2:0] C_EXEC = 3'd0;
  localparam logic [2:0] C_CTI  = 3'd1;
  localparam logic [2:0] C_LOAD = 3'd2;
  localparam logic [2:0] C_STOR = 3'd3;

  logic [NREG-1:0] act_mask;

  wire is_ex  = cls_i == C_EXEC;
  wire is_cti = cls_i == C_CTI;
  wire is_ld  = cls_i == C_LOAD;
  wire is_st  = cls_i == C_STOR;

  wire chk_a = is_ex | is_st | is_cti | is_ld;
  wire chk_b = is_ex | is_st;

  wire hit_a   = chk_a & src_a_vld_i & act_mask[src_a_i];
  wire hit_b   = chk_b & src_b_vld_i & act_mask[src_b_i];
  wire cti_pen = is_cti & taken_i & ~dslot_i;

  wire [1:0] nstall = {1'b0, hit_a} + {1'b0, hit_b};

  assign cost_o = COST_W'(base_i) + COST_W'(nstall) + COST_W'(cti_pen);

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [COST_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + (CNT_W+1)'(b);
    return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      act_mask    <= '0;
      last_cost_o <= '0;
      tot_o       <= '0;
      ld_stall_o  <= '0;
      cti_stall_o <= '0;
      taken_o     <= '0;
      untaken_o   <= '0;
    end else if (ret_i) begin
      act_mask    <= is_ld ? (NREG'(1) << ld_dst_i) : '0;
      last_cost_o <= cost_o;
      tot_o       <= sat_add(tot_o, cost_o);
      ld_stall_o  <= sat_add(ld_stall_o, COST_W'(nstall));
      cti_stall_o <= sat_add(cti_stall_o, COST_W'(cti_pen));
      taken_o     <= sat_add(taken_o, COST_W'(is_cti & taken_i));
      untaken_o   <= sat_add(untaken_o, COST_W'(is_cti & ~taken_i));
    end
  end

  p_cost_range_r2: assert property (@(posedge clk) disable iff (rst)
    ret_i |-> (cost_o >= COST_W'(base_i)) && (cost_o <= COST_W'(base_i) + COST_W'(3)));

  p_no_src_r5: assert property (@(posedge clk) disable iff (rst)
    ret_i && !src_a_vld_i && !src_b_vld_i && !is_cti |-> cost_o == COST_W'(base_i));

  p_block_r8: assert property (@(posedge clk) disable iff (rst)
    ret_i && cls_i[2] |-> cost_o == COST_W'(base_i));

  p_last_r9: assert property (@(posedge clk) disable iff (rst)
    ret_i |=> last_cost_o == $past(cost_o));

  p_tk_other_r7: assert property (@(posedge clk) disable iff (rst)
    ret_i && !is_cti |=> $stable(taken_o) && $stable(untaken_o) && $stable(cti_stall_o));

  p_no_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    ret_i |=> tot_o >= $past(tot_o));

  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !ret_i |=> $stable(tot_o) && $stable(last_cost_o) && $stable(ld_stall_o));

endmodule

// File: tb/cyc_acct_tb_top.sv
module cyc_acct_tb_top;
  localparam int CW = 12;
  localparam int BW = 8;
  localparam int NR = 16;
  localparam int COSTW = BW + 2;
  localparam int SATV = (1 << CW) - 1;

  logic clk = 0;
  logic rst = 1;
  logic ret = 0;
  logic [2:0] cls = 0;
  logic [BW-1:0] base = 0;
  logic [3:0] sa = 0, sb = 0, dst = 0;
  logic sav = 0, sbv = 0, tk = 0, ds = 0;
  logic [COSTW-1:0] cost, last_cost;
  logic [CW-1:0] tot, lds, cts, tkc, ntc;

  always #10 clk = ~clk;

  cyc_acct #(.CNT_W(CW), .BASE_W(BW), .NREG(NR)) dut_i (
    .clk(clk), .rst(rst), .ret_i(ret), .cls_i(cls), .base_i(base),
    .src_a_i(sa), .src_a_vld_i(sav), .src_b_i(sb), .src_b_vld_i(sbv),
    .ld_dst_i(dst), .taken_i(tk), .dslot_i(ds), .cost_o(cost),
    .last_cost_o(last_cost), .tot_o(tot), .ld_stall_o(lds),
    .cti_stall_o(cts), .taken_o(tkc), .untaken_o(ntc));

  typedef struct {
    int last, tot, ld, ct, tk, nt;
    string tag;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_err = 0;
  int m_mask = 0, m_tot = 0, m_ld = 0, m_ct = 0, m_tk = 0, m_nt = 0, m_last = 0;

  task automatic chk(string req, string what, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int sat(int a, int b);
    return (a + b > SATV) ? SATV : a + b;
  endfunction

  task automatic retire(string tag, int c, int b, int a_i, int a_v, int b_i, int b_v,
                        int d, int t, int s);
    int ha, hb, pen, ecost;
    exp_t e;
    ha = ((c <= 3) && a_v != 0 && ((m_mask >> a_i) & 1) != 0) ? 1 : 0;
    hb = ((c == 0 || c == 3) && b_v != 0 && ((m_mask >> b_i) & 1) != 0) ? 1 : 0;
    pen = (c == 1 && t != 0 && s == 0) ? 1 : 0;
    ecost = b + ha + hb + pen;
    @(negedge clk);
    ret = 1; cls = 3'(c); base = BW'(b); sa = 4'(a_i); sav = 1'(a_v);
    sb = 4'(b_i); sbv = 1'(b_v); dst = 4'(d); tk = 1'(t); ds = 1'(s);
    #1 chk(tag, "cost", int'(cost), ecost);
    m_tot = sat(m_tot, ecost);
    m_ld  = sat(m_ld, ha + hb);
    m_ct  = sat(m_ct, pen);
    if (c == 1) begin
      if (t != 0) m_tk = sat(m_tk, 1); else m_nt = sat(m_nt, 1);
    end
    m_last = ecost;
    m_mask = (c == 2) ? (1 << d) : 0;
    e.last = m_last; e.tot = m_tot; e.ld = m_ld; e.ct = m_ct; e.tk = m_tk; e.nt = m_nt;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    ret = 0; cls = 3'd5; sa = 4'd15; sav = 1; tk = 1;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic chk_all(string tag);
    chk(tag, "last", int'(last_cost), m_last);
    chk(tag, "tot", int'(tot), m_tot);
    chk(tag, "ldstall", int'(lds), m_ld);
    chk(tag, "ctistall", int'(cts), m_ct);
    chk(tag, "taken", int'(tkc), m_tk);
    chk(tag, "untaken", int'(ntc), m_nt);
  endtask

  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      if (!rst && ret) begin
        #5;
        if (q.size() == 0) begin
          chk("scoreboard", "queue", 0, 1);
        end else begin
          e = q.pop_front();
          chk(e.tag, "last", int'(last_cost), e.last);
          chk(e.tag, "tot", int'(tot), e.tot);
          chk(e.tag, "ldstall", int'(lds), e.ld);
          chk(e.tag, "ctistall", int'(cts), e.ct);
          chk(e.tag, "taken", int'(tkc), e.tk);
          chk(e.tag, "untaken", int'(ntc), e.nt);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk_all("R1");
    retire("R1", 0, 2, 0, 1, 0, 1, 0, 0, 0);
    // R3: load r5, then use it in both sources of an execute
    retire("R3", 2, 3, 1, 1, 0, 0, 5, 0, 0);
    retire("R3", 0, 1, 5, 1, 5, 1, 0, 0, 0);
    // R3: stall only for the very next instruction
    retire("R3", 2, 3, 1, 1, 0, 0, 6, 0, 0);
    retire("R2", 0, 1, 2, 1, 3, 1, 0, 0, 0);
    retire("R3", 0, 1, 6, 1, 6, 1, 0, 0, 0);
    // R3/R11: idle cycles keep the mask and the counters
    retire("R3", 2, 2, 0, 0, 0, 0, 7, 0, 0);
    idle(4);
    chk_all("R11");
    retire("R3", 3, 1, 0, 0, 7, 1, 0, 0, 0);
    // R4: load checks only address register; source B ignored
    retire("R4", 2, 2, 0, 0, 0, 0, 9, 0, 0);
    retire("R4", 2, 2, 1, 1, 9, 1, 10, 0, 0);
    retire("R4", 2, 2, 10, 1, 0, 0, 11, 0, 0);
    // R4: control transfer ignores source B
    retire("R4", 1, 1, 0, 0, 11, 1, 0, 0, 1);
    retire("R4", 2, 1, 0, 0, 0, 0, 12, 0, 0);
    retire("R4", 1, 1, 12, 1, 0, 0, 0, 1, 0);
    // R5: invalid sources naming the loaded register
    retire("R5", 2, 1, 0, 0, 0, 0, 4, 0, 0);
    retire("R5", 0, 1, 4, 0, 4, 0, 0, 0, 0);
    // R6/R7: branch kinds
    retire("R6", 1, 2, 0, 0, 0, 0, 0, 1, 0);
    retire("R6", 1, 2, 0, 0, 0, 0, 0, 1, 1);
    retire("R7", 1, 2, 0, 0, 0, 0, 0, 0, 0);
    retire("R7", 1, 2, 0, 0, 0, 0, 0, 0, 1);
    retire("R7", 0, 1, 0, 0, 0, 0, 0, 1, 0);
    // R8: block transfers ignore mask and clear it
    retire("R8", 2, 1, 0, 0, 0, 0, 8, 0, 0);
    retire("R8", 4, 5, 8, 1, 8, 1, 0, 0, 0);
    retire("R8", 0, 1, 8, 1, 0, 0, 0, 0, 0);
    retire("R8", 2, 1, 0, 0, 0, 0, 8, 0, 0);
    retire("R8", 5, 4, 8, 1, 8, 1, 0, 0, 0);
    retire("R8", 2, 1, 0, 0, 0, 0, 8, 0, 0);
    retire("R8", 7, 3, 8, 1, 8, 1, 0, 0, 0);
    retire("R9", 3, 6, 0, 1, 1, 1, 0, 0, 0);
    idle(2);
    chk_all("R9");
    // R10: saturate the total
    for (int i = 0; i < 18; i++) retire("R10", 0, 255, 0, 0, 0, 0, 0, 0, 0);
    idle(2);
    chk_all("R10");
    chk("R10", "tot_sat", int'(tot), SATV);
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule